// File: doc/BRIEF.md
# Dual-Channel Log Volume Wiper Controller

This block keeps the tap positions of a stereo pair of log-taper attenuators. Each channel owns a 5-bit wiper position that picks one of 32 taps. A parallel command port carries three operations: load a value, step up, or step down. Each command is aimed at the left channel, the right channel, or both at once. Each applied position is decoded into a one-hot tap-switch vector. It is also mapped to the attenuation it gives, as a signed dB number.

A command never moves a wiper at once. It sets a pending target for each addressed channel. The target is applied only when that channel's zero-crossing strobe is sampled high, so that a volume change cannot click. Each channel is a two-state machine. `CH_IDLE` moves to `CH_PENDING` on any accepted command. `CH_PENDING` stays in place on a further command, which folds into the target. `CH_PENDING` goes back to `CH_IDLE` on a crossing that arrives with no new command; at that crossing the target is copied to the applied position. A crossing that arrives together with a command applies the old target and keeps the channel in `CH_PENDING` with the new one. The command decoder flags a malformed command with a single-cycle pulse.

Top module: `stereo_wiper_ctrl`

## Requirements
- R1: After reset, both applied wipers read 0 (mute), both tap vectors have only bit 0 set, both dB outputs read -92, and neither channel is pending.
- R2: Each tap-select vector has exactly one bit set, at the index equal to that channel's applied wiper.
- R3: Channel select `cmd_sel` bit 0 addresses the left channel and bit 1 the right; the value 2'b11 addresses both in the same cycle.
- R4: Operation codes on `cmd_op`: 2'b00 loads `cmd_data`, 2'b01 adds one step, 2'b10 removes one step. The code 2'b11 is reserved.
- R5: An accepted command raises the addressed channel's pending flag in the next cycle and leaves its applied wiper unchanged. The applied wiper changes only in the cycle after its own channel's strobe is sampled high while pending; the other channel's strobe has no effect.
- R6: The dB output of a tap n is n-31 for n in 20..31, 2n-51 for 10..19, 3n-61 for 5..9, 4n-66 for 1..4, and -92 for n=0, giving 0 to -62 dB plus mute.
- R7: A step up from 31 stays at 31, and a step down from 0 stays at 0.
- R8: A step command issued while pending is applied to the pending target, not to the applied wiper, so several commands before a crossing accumulate and only the final target is applied.
- R9: A crossing with no same-cycle command clears the pending flag. A crossing that arrives with a command applies the previous target and leaves the channel pending on the new target.
- R10: A valid command with `cmd_sel` equal to 0, or with the reserved operation code, raises `cmd_invalid` for exactly one cycle. It changes neither channel's pending flag nor its wiper.
- R11: The wiper readback ports always show the applied position, never the pending target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Operation code |
| cmd_sel | input | 2 | Channel select, bit 0 left, bit 1 right |
| cmd_data | input | 5 | Tap value for a load |
| zc_left | input | 1 | Left zero-crossing strobe |
| zc_right | input | 1 | Right zero-crossing strobe |
| tap_sel_left | output | 32 | One-hot left tap switches |
| tap_sel_right | output | 32 | One-hot right tap switches |
| wiper_left | output | 5 | Applied left tap |
| wiper_right | output | 5 | Applied right tap |
| pend_left | output | 1 | Left update pending |
| pend_right | output | 1 | Right update pending |
| db_left | output | 8 | Left attenuation, signed dB |
| db_right | output | 8 | Right attenuation, signed dB |
| cmd_invalid | output | 1 | One-cycle flag for a rejected command |

## Verification
The bench builds the block with its defaults: 5 tap bits, so there are 32 taps, and an 8-bit dB word. At that size every tap can be reached by a load, which lets the bench sweep all five segments of the dB map and cross each segment boundary. Both saturation ends can be reached in a single step. The directed scenarios place the strobes against the commands, on the same channel and on the opposite one, and in the same cycle as a command. This reaches both exits from the pending state.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10,
        OP_RSVD = 2'b11
    } wiper_op_e;

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_PENDING = 1'b1
    } ch_state_e;

    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned CH_LEFT  = 0;
    localparam int unsigned CH_RIGHT = 1;

endpackage

// File: rtl/tap_onehot_dec.sv
module tap_onehot_dec #(
    parameter int unsigned TAP_BITS = 5,
    localparam int unsigned NUM_TAPS = 1 << TAP_BITS
) (
    input  logic [TAP_BITS-1:0] tap,
    output logic [NUM_TAPS-1:0] sel
);

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_line
        assign sel[i] = (tap == TAP_BITS'(i));
    end

endmodule

// File: rtl/tap_db_map.sv
module tap_db_map #(
    parameter int unsigned TAP_BITS = 5,
    parameter int unsigned DB_W     = 8
) (
    input  logic [TAP_BITS-1:0]     tap,
    output logic signed [DB_W-1:0]  db
);

    // Segment lower bounds and per-segment offsets of the log taper.
    localparam int SEG1_LO  = 20;
    localparam int SEG2_LO  = 10;
    localparam int SEG3_LO  = 5;
    localparam int SEG4_LO  = 1;
    localparam int MUTE_DB  = -92;

    int n;
    int val;

    always_comb begin
        n = int'(tap);
        if (n >= SEG1_LO) begin
            val = n - 31;
        end else if (n >= SEG2_LO) begin
            val = 2 * n - 51;
        end else if (n >= SEG3_LO) begin
            val = 3 * n - 61;
        end else if (n >= SEG4_LO) begin
            val = 4 * n - 66;
        end else begin
            val = MUTE_DB;
        end
        db = val[DB_W-1:0];
    end

endmodule

// File: rtl/wiper_channel.sv
module wiper_channel
    import wiper_pkg::*;
#(
    parameter int unsigned TAP_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  wiper_op_e           op,
    input  logic [TAP_BITS-1:0] data,
    input  logic                zc,
    output logic [TAP_BITS-1:0] applied_o,
    output logic                pending_o
);

    localparam logic [TAP_BITS-1:0] TAP_TOP = '1;
    localparam logic [TAP_BITS-1:0] TAP_BOT = '0;
    localparam logic [TAP_BITS-1:0] STEP    = TAP_BITS'(1);

    ch_state_e           state_q, state_d;
    logic [TAP_BITS-1:0] applied_q;
    logic [TAP_BITS-1:0] target_q;
    logic [TAP_BITS-1:0] base;
    logic [TAP_BITS-1:0] next_target;

    // Steps fold onto the pending target when one exists.
    always_comb begin
        base = (state_q == CH_PENDING) ? target_q : applied_q;
        unique case (op)
            OP_LOAD: next_target = data;
            OP_UP:   next_target = (base == TAP_TOP) ? base : base + STEP;
            OP_DOWN: next_target = (base == TAP_BOT) ? base : base - STEP;
            default: next_target = base;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (hit) state_d = CH_PENDING;
            end
            CH_PENDING: begin
                if (zc && !hit) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            applied_q <= TAP_BOT;
            target_q  <= TAP_BOT;
        end else begin
            if (state_q == CH_PENDING && zc) begin
                applied_q <= target_q;
            end
            if (hit) begin
                target_q <= next_target;
            end
        end
    end

    always_comb begin
        applied_o = applied_q;
        pending_o = (state_q == CH_PENDING);
    end

endmodule

// File: rtl/stereo_wiper_ctrl.sv
module stereo_wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int unsigned TAP_BITS = 5,
    parameter int unsigned DB_W     = 8,
    localparam int unsigned NUM_TAPS = 1 << TAP_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [1:0]             cmd_sel,
    input  logic [TAP_BITS-1:0]    cmd_data,
    input  logic                   zc_left,
    input  logic                   zc_right,
    output logic [NUM_TAPS-1:0]    tap_sel_left,
    output logic [NUM_TAPS-1:0]    tap_sel_right,
    output logic [TAP_BITS-1:0]    wiper_left,
    output logic [TAP_BITS-1:0]    wiper_right,
    output logic                   pend_left,
    output logic                   pend_right,
    output logic signed [DB_W-1:0] db_left,
    output logic signed [DB_W-1:0] db_right,
    output logic                   cmd_invalid
);

    wiper_op_e op;
    logic      cmd_ok;
    logic      cmd_bad;
    logic      invalid_q;

    logic [NUM_CH-1:0]        zc_vec;
    logic [NUM_CH-1:0]        hit_vec;
    logic [NUM_CH-1:0]        pend_vec;
    logic [TAP_BITS-1:0]      wiper_arr [NUM_CH];
    logic [NUM_TAPS-1:0]      tap_arr   [NUM_CH];
    logic signed [DB_W-1:0]   db_arr    [NUM_CH];

    always_comb begin
        op      = wiper_op_e'(cmd_op);
        cmd_bad = cmd_valid && ((cmd_sel == 2'b00) || (op == OP_RSVD));
        cmd_ok  = cmd_valid && !cmd_bad;
        zc_vec[CH_LEFT]  = zc_left;
        zc_vec[CH_RIGHT] = zc_right;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            invalid_q <= 1'b0;
        end else begin
            invalid_q <= cmd_bad;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit_vec[c] = cmd_ok && cmd_sel[c];

        wiper_channel #(
            .TAP_BITS (TAP_BITS)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit_vec[c]),
            .op        (op),
            .data      (cmd_data),
            .zc        (zc_vec[c]),
            .applied_o (wiper_arr[c]),
            .pending_o (pend_vec[c])
        );

        tap_onehot_dec #(
            .TAP_BITS (TAP_BITS)
        ) u_dec (
            .tap (wiper_arr[c]),
            .sel (tap_arr[c])
        );

        tap_db_map #(
            .TAP_BITS (TAP_BITS),
            .DB_W     (DB_W)
        ) u_db (
            .tap (wiper_arr[c]),
            .db  (db_arr[c])
        );
    end

    always_comb begin
        tap_sel_left  = tap_arr[CH_LEFT];
        tap_sel_right = tap_arr[CH_RIGHT];
        wiper_left    = wiper_arr[CH_LEFT];
        wiper_right   = wiper_arr[CH_RIGHT];
        pend_left     = pend_vec[CH_LEFT];
        pend_right    = pend_vec[CH_RIGHT];
        db_left       = db_arr[CH_LEFT];
        db_right      = db_arr[CH_RIGHT];
        cmd_invalid   = invalid_q;
    end

endmodule

// File: rtl/stereo_wiper_ctrl_checker.sv
module stereo_wiper_ctrl_checker #(
    parameter int unsigned TAP_BITS = 5,
    parameter int unsigned DB_W     = 8,
    localparam int unsigned NUM_TAPS = 1 << TAP_BITS
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [1:0]             cmd_op,
    input logic [1:0]             cmd_sel,
    input logic [TAP_BITS-1:0]    cmd_data,
    input logic                   zc_left,
    input logic                   zc_right,
    input logic [NUM_TAPS-1:0]    tap_sel_left,
    input logic [NUM_TAPS-1:0]    tap_sel_right,
    input logic [TAP_BITS-1:0]    wiper_left,
    input logic [TAP_BITS-1:0]    wiper_right,
    input logic                   pend_left,
    input logic                   pend_right,
    input logic signed [DB_W-1:0] db_left,
    input logic signed [DB_W-1:0] db_right,
    input logic                   cmd_invalid
);

    logic bad_cmd;
    logic hit_l;
    logic hit_r;
    assign bad_cmd = cmd_valid && (cmd_sel == 2'b00 || cmd_op == 2'b11);
    assign hit_l   = cmd_valid && cmd_sel[0] && cmd_op != 2'b11;
    assign hit_r   = cmd_valid && cmd_sel[1] && cmd_op != 2'b11;

    assert_reset_mute_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wiper_left == '0 && wiper_right == '0 && !pend_left && !pend_right));

    assert_tap_onehot_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel_left) == 1 && tap_sel_left[wiper_left]);

    assert_tap_onehot_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel_right) == 1 && tap_sel_right[wiper_right]);

    assert_move_needs_zc_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_left) |-> ($past(zc_left) && $past(pend_left)));

    assert_move_needs_zc_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_right) |-> ($past(zc_right) && $past(pend_right)));

    assert_pend_raise_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_l |=> pend_left);

    assert_db_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        db_left <= 0 && db_left >= -92 && db_right <= 0 && db_right >= -92);

    assert_pend_clear_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_left && zc_left && !hit_l) |=> !pend_left);

    assert_pend_clear_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_right && zc_right && !hit_r) |=> !pend_right);

    assert_invalid_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> cmd_invalid);

    assert_invalid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_cmd |=> !cmd_invalid);

    assert_invalid_no_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_cmd && !pend_left && !pend_right) |=> (!pend_left && !pend_right));

endmodule

bind stereo_wiper_ctrl stereo_wiper_ctrl_checker #(
    .TAP_BITS (TAP_BITS),
    .DB_W     (DB_W)
) chk_i (.*);

// File: tb/stereo_wiper_ctrl_tb.sv
`timescale 1ns/1ps
module stereo_wiper_ctrl_tb_top;

    localparam int TAP_BITS = 5;
    localparam int DB_W     = 8;
    localparam int NUM_TAPS = 1 << TAP_BITS;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   cmd_valid;
    logic [1:0]             cmd_op;
    logic [1:0]             cmd_sel;
    logic [TAP_BITS-1:0]    cmd_data;
    logic                   zc_left;
    logic                   zc_right;
    logic [NUM_TAPS-1:0]    tap_sel_left;
    logic [NUM_TAPS-1:0]    tap_sel_right;
    logic [TAP_BITS-1:0]    wiper_left;
    logic [TAP_BITS-1:0]    wiper_right;
    logic                   pend_left;
    logic                   pend_right;
    logic signed [DB_W-1:0] db_left;
    logic signed [DB_W-1:0] db_right;
    logic                   cmd_invalid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    stereo_wiper_ctrl #(.TAP_BITS(TAP_BITS), .DB_W(DB_W)) dut_i (.*);

    function automatic int db_ref(int n);
        if (n >= 20) return n - 31;
        if (n >= 10) return 2 * n - 51;
        if (n >= 5)  return 3 * n - 61;
        if (n >= 1)  return 4 * n - 66;
        return -92;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_cmd(logic [1:0] op, logic [1:0] sel, int data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_sel   = sel;
        cmd_data  = TAP_BITS'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_zc(logic l, logic r);
        @(negedge clk);
        zc_left  = l;
        zc_right = r;
        @(negedge clk);
        zc_left  = 1'b0;
        zc_right = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "wiper_left", int'(wiper_left), 0);
        chk("R1", "wiper_right", int'(wiper_right), 0);
        chk("R1", "tap_sel_left", int'(tap_sel_left == 32'h1), 1);
        chk("R1", "tap_sel_right", int'(tap_sel_right == 32'h1), 1);
        chk("R1", "db_left", int'(db_left), -92);
        chk("R1", "pending", int'({pend_left, pend_right}), 0);
    endtask

    task automatic t_deferral();
        do_cmd(2'b00, 2'b01, 20);
        chk("R5", "pend_left after load", int'(pend_left), 1);
        chk("R11", "wiper_left shows applied", int'(wiper_left), 0);
        chk("R3", "right not addressed", int'(pend_right), 0);
        do_zc(1'b0, 1'b1);
        chk("R5", "right strobe ignored by left", int'(wiper_left), 0);
        do_zc(1'b1, 1'b0);
        chk("R5", "left applied at crossing", int'(wiper_left), 20);
        chk("R9", "pend_left cleared", int'(pend_left), 0);
        chk("R6", "db_left at 20", int'(db_left), -11);
        chk("R2", "tap_sel_left bit 20", int'(tap_sel_left == (32'h1 << 20)), 1);
    endtask

    task automatic t_both();
        do_cmd(2'b00, 2'b11, 31);
        chk("R3", "both pending", int'({pend_left, pend_right}), 3);
        do_zc(1'b1, 1'b1);
        chk("R3", "left at 31", int'(wiper_left), 31);
        chk("R3", "right at 31", int'(wiper_right), 31);
        chk("R6", "db_right at 31", int'(db_right), 0);
    endtask

    task automatic t_saturate();
        do_cmd(2'b01, 2'b01, 0);
        do_zc(1'b1, 1'b0);
        chk("R7", "step up at top", int'(wiper_left), 31);
        do_cmd(2'b00, 2'b10, 0);
        do_zc(1'b0, 1'b1);
        do_cmd(2'b10, 2'b10, 0);
        do_zc(1'b0, 1'b1);
        chk("R7", "step down at bottom", int'(wiper_right), 0);
        do_cmd(2'b01, 2'b10, 0);
        do_zc(1'b0, 1'b1);
        chk("R4", "step up from 0", int'(wiper_right), 1);
    endtask

    task automatic t_cumulative();
        do_cmd(2'b10, 2'b01, 0);
        do_cmd(2'b10, 2'b01, 0);
        do_cmd(2'b10, 2'b01, 0);
        chk("R11", "applied unchanged while pending", int'(wiper_left), 31);
        do_zc(1'b1, 1'b0);
        chk("R8", "three steps down", int'(wiper_left), 28);
        do_cmd(2'b00, 2'b01, 5);
        do_cmd(2'b01, 2'b01, 0);
        do_zc(1'b1, 1'b0);
        chk("R8", "load then step", int'(wiper_left), 6);
        chk("R6", "db at 6", int'(db_left), -43);
    endtask

    task automatic t_same_cycle();
        do_cmd(2'b00, 2'b01, 10);
        @(negedge clk);
        zc_left = 1'b1; cmd_valid = 1'b1; cmd_op = 2'b00; cmd_sel = 2'b01; cmd_data = 5'd12;
        @(negedge clk);
        zc_left = 1'b0; cmd_valid = 1'b0;
        chk("R9", "old target applied", int'(wiper_left), 10);
        chk("R9", "still pending", int'(pend_left), 1);
        do_zc(1'b1, 1'b0);
        chk("R9", "new target applied", int'(wiper_left), 12);
        chk("R9", "pending cleared", int'(pend_left), 0);
    endtask

    task automatic t_invalid();
        int wl;
        int wr;
        wl = int'(wiper_left);
        wr = int'(wiper_right);
        do_cmd(2'b00, 2'b00, 7);
        chk("R10", "flag on empty select", int'(cmd_invalid), 1);
        chk("R10", "no pending", int'({pend_left, pend_right}), 0);
        @(negedge clk);
        chk("R10", "flag one cycle", int'(cmd_invalid), 0);
        do_cmd(2'b11, 2'b11, 3);
        chk("R10", "flag on reserved op", int'(cmd_invalid), 1);
        chk("R4", "reserved op no pending", int'({pend_left, pend_right}), 0);
        do_zc(1'b1, 1'b1);
        chk("R10", "left unchanged", int'(wiper_left), wl);
        chk("R10", "right unchanged", int'(wiper_right), wr);
    endtask

    task automatic t_sweep();
        for (int n = 0; n < NUM_TAPS; n++) begin
            do_cmd(2'b00, 2'b11, n);
            do_zc(1'b1, 1'b1);
            chk("R6", $sformatf("db_left tap %0d", n), int'(db_left), db_ref(n));
            chk("R6", $sformatf("db_right tap %0d", n), int'(db_right), db_ref(n));
            chk("R2", $sformatf("tap_sel_left tap %0d", n),
                int'(tap_sel_left == (32'h1 << n)), 1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_sel = 2'b00;
        cmd_data = '0; zc_left = 1'b0; zc_right = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_deferral();
        t_both();
        t_saturate();
        t_cumulative();
        t_same_cycle();
        t_invalid();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule